// File: doc/BRIEF.md
# Edge Change Interrupt Controller

This block watches a group of byte-wide digital input ports and raises a level interrupt toward a host when selected bits change. Every input bit has its own rising-transition and falling-transition enable, held per port in byte registers. Two global polarity switches in the control register gate all rising detections or all falling detections at once. The input bits must already be synchronised to the block clock and filtered.

Any qualifying transition sets a sticky edge flag. A qualifying transition that arrives while the edge flag is still set also sets a sticky overflow flag, so the host can see that it missed an event. The host reads a status byte and clears the flags through write-one bits in a clear register. The interrupt line is the master enable ANDed with the enabled flags. The normal host sequence is: check that status shows both the pending bit and the edge bit, then write both clear bits in one access.

The register interface is a single-cycle byte port with a write strobe and a combinational read path. Register offsets that host code depends on are kept at fixed positions: clear 0x01, status 0x02, control 0x03, rising mask of port p at 0x42 + 0x10*p, and falling mask of port p at 0x43 + 0x10*p.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset, both flags, the control register and all mask registers are zero, irqOut is low, and every register reads 0x00.
- R2: The rising mask of port p reads back at 0x42 + 0x10*p and the falling mask at 0x43 + 0x10*p, exactly as written. The control register at 0x03 reads back its low five bits, and bits 7..5 read zero.
- R3: A bit going 0→1 with its rising mask bit set while control bit 3 (rising on) is 1 sets the edge flag (status bit 0). The same holds for a 1→0 change with its falling mask bit set while control bit 4 (falling on) is 1. The flag is visible after the first clock edge that samples the new input value.
- R4: A change on a bit whose mask bit for that direction is clear, or whose global polarity bit is clear, leaves both flags unchanged.
- R5: A qualifying change sampled while the edge flag is already set sets the overflow flag (status bit 1). The overflow flag stays set until it is cleared.
- R6: A write to 0x01 with bit 3 set clears the edge flag, and a write with bit 2 set clears the overflow flag. Each clear acts independently of the other.
- R7: When a clear of the edge flag and a new qualifying change fall in the same cycle, the edge flag stays set.
- R8: irqOut equals control bit 2 (master) AND ((edge flag AND control bit 0) OR (overflow flag AND control bit 1)). Status bit 2 always equals irqOut, and status bits 7..3 read zero.
- R9: Writing 0x00 to the control register drives irqOut low from the next cycle on. The flags are left as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinsIn | input | NUM_PORTS*DATA_W | Synchronised input bits; port p occupies bits p*DATA_W upward |
| regWe | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register byte address |
| regWdata | input | DATA_W | Write data |
| regRdata | output | DATA_W | Read data for regAddr, combinational |
| irqOut | output | 1 | Level interrupt to the host |

## Verification
Several properties are checked on every cycle. A detected change always leaves the edge flag set, even against a same-cycle clear. The overflow flag is set by a change sampled while the edge flag was set, and it holds until its clear bit is written. An uncontested clear empties the edge flag, the status pending bit mirrors irqOut, and the interrupt is never raised with both flags empty. Only the bench scenarios can show that the per-bit masks and the polarity switches select the right bits across ports, that mask and control registers read back correctly, and that irqOut follows the full enable combination under mixed random traffic.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;

  // Fixed register offsets that host software decodes.
  localparam int OFS_CLEAR     = 'h01;
  localparam int OFS_STATUS    = 'h02;
  localparam int OFS_CTRL      = 'h03;
  localparam int OFS_RISE_BASE = 'h42;
  localparam int OFS_FALL_BASE = 'h43;
  localparam int OFS_STRIDE    = 'h10;

  // Bit positions in the clear register.
  localparam int CLR_OVF_BIT  = 2;
  localparam int CLR_EDGE_BIT = 3;

  localparam int CTRL_W = 5;

  // Control register, bit 0 first from the right.
  typedef struct packed {
    logic fallOn;    // bit 4
    logic riseOn;    // bit 3
    logic masterEn;  // bit 2
    logic ovfIe;     // bit 1
    logic edgeIe;    // bit 0
  } ctrlReg_t;

  // Strobes from the register block to the detect datapath.
  typedef struct packed {
    logic clrEdge;
    logic clrOvf;
    logic riseOn;
    logic fallOn;
  } detStrobe_t;

endpackage

// File: rtl/edge_irq_detect.sv
module edge_irq_detect
  import edge_irq_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int DATA_W    = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_PORTS*DATA_W-1:0]   pinsIn,
  input  logic [NUM_PORTS*DATA_W-1:0]   riseMask,
  input  logic [NUM_PORTS*DATA_W-1:0]   fallMask,
  input  detStrobe_t                    strobe,
  output logic                          edgeFlag,
  output logic                          ovfFlag,
  output logic                          edgeNow
);

  localparam int PIN_W = NUM_PORTS * DATA_W;

  logic [PIN_W-1:0] prevQ;
  logic [PIN_W-1:0] riseHits;
  logic [PIN_W-1:0] fallHits;

  always_ff @(posedge clk) begin
    if (!rstN) prevQ <= '0;
    else       prevQ <= pinsIn;
  end

  assign riseHits = pinsIn & ~prevQ & riseMask;
  assign fallHits = ~pinsIn & prevQ & fallMask;
  assign edgeNow  = (strobe.riseOn && (|riseHits)) ||
                    (strobe.fallOn && (|fallHits));

  // A new event takes priority over a same-cycle clear.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      edgeFlag <= 1'b0;
      ovfFlag  <= 1'b0;
    end else begin
      if (edgeNow)             edgeFlag <= 1'b1;
      else if (strobe.clrEdge) edgeFlag <= 1'b0;

      if (edgeNow && edgeFlag) ovfFlag <= 1'b1;
      else if (strobe.clrOvf)  ovfFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/edge_irq_regs.sv
module edge_irq_regs
  import edge_irq_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          regWe,
  input  logic [ADDR_W-1:0]             regAddr,
  input  logic [DATA_W-1:0]             regWdata,
  input  logic                          edgeFlag,
  input  logic                          ovfFlag,
  output logic [NUM_PORTS*DATA_W-1:0]   riseMask,
  output logic [NUM_PORTS*DATA_W-1:0]   fallMask,
  output detStrobe_t                    strobe,
  output logic [DATA_W-1:0]             regRdata,
  output logic                          irqOut
);

  localparam logic [ADDR_W-1:0] A_CLEAR  = ADDR_W'(OFS_CLEAR);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);

  logic [NUM_PORTS-1:0][DATA_W-1:0] riseQ;
  logic [NUM_PORTS-1:0][DATA_W-1:0] fallQ;
  ctrlReg_t ctrlQ;
  logic clearWr;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam logic [ADDR_W-1:0] A_RISE = ADDR_W'(OFS_RISE_BASE + p * OFS_STRIDE);
    localparam logic [ADDR_W-1:0] A_FALL = ADDR_W'(OFS_FALL_BASE + p * OFS_STRIDE);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        riseQ[p] <= '0;
        fallQ[p] <= '0;
      end else if (regWe) begin
        if (regAddr == A_RISE) riseQ[p] <= regWdata;
        if (regAddr == A_FALL) fallQ[p] <= regWdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                          ctrlQ <= '0;
    else if (regWe && regAddr == A_CTRL) ctrlQ <= ctrlReg_t'(regWdata[CTRL_W-1:0]);
  end

  assign riseMask = riseQ;
  assign fallMask = fallQ;

  assign clearWr        = regWe && (regAddr == A_CLEAR);
  assign strobe.clrEdge = clearWr && regWdata[CLR_EDGE_BIT];
  assign strobe.clrOvf  = clearWr && regWdata[CLR_OVF_BIT];
  assign strobe.riseOn  = ctrlQ.riseOn;
  assign strobe.fallOn  = ctrlQ.fallOn;

  assign irqOut = ctrlQ.masterEn &&
                  ((edgeFlag && ctrlQ.edgeIe) || (ovfFlag && ctrlQ.ovfIe));

  always_comb begin
    regRdata = '0;
    if (regAddr == A_STATUS) begin
      regRdata[0] = edgeFlag;
      regRdata[1] = ovfFlag;
      regRdata[2] = irqOut;
    end else if (regAddr == A_CTRL) begin
      regRdata = DATA_W'(ctrlQ);
    end
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (regAddr == ADDR_W'(OFS_RISE_BASE + p * OFS_STRIDE)) regRdata = riseQ[p];
      if (regAddr == ADDR_W'(OFS_FALL_BASE + p * OFS_STRIDE)) regRdata = fallQ[p];
    end
  end

endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
  import edge_irq_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_PORTS*DATA_W-1:0]   pinsIn,
  input  logic                          regWe,
  input  logic [ADDR_W-1:0]             regAddr,
  input  logic [DATA_W-1:0]             regWdata,
  output logic [DATA_W-1:0]             regRdata,
  output logic                          irqOut
);

  localparam int PIN_W = NUM_PORTS * DATA_W;

  logic [PIN_W-1:0] riseMask;
  logic [PIN_W-1:0] fallMask;
  detStrobe_t       strobe;
  logic             edgeFlag;
  logic             ovfFlag;
  logic             edgeNow;

  edge_irq_regs #(
    .NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rstN(rstN),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .edgeFlag(edgeFlag), .ovfFlag(ovfFlag),
    .riseMask(riseMask), .fallMask(fallMask),
    .strobe(strobe), .regRdata(regRdata), .irqOut(irqOut)
  );

  edge_irq_detect #(
    .NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W)
  ) u_detect (
    .clk(clk), .rstN(rstN), .pinsIn(pinsIn),
    .riseMask(riseMask), .fallMask(fallMask), .strobe(strobe),
    .edgeFlag(edgeFlag), .ovfFlag(ovfFlag), .edgeNow(edgeNow)
  );

endmodule

// File: rtl/edge_irq_checker.sv
module edge_irq_checker
  import edge_irq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWe,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWdata,
  input logic [DATA_W-1:0] regRdata,
  input logic              irqOut,
  input logic              edgeFlag,
  input logic              ovfFlag,
  input logic              edgeNow
);

  logic clrEdgeWr, clrOvfWr, ctrlZeroWr;
  assign clrEdgeWr  = regWe && regAddr == ADDR_W'(OFS_CLEAR) && regWdata[CLR_EDGE_BIT];
  assign clrOvfWr   = regWe && regAddr == ADDR_W'(OFS_CLEAR) && regWdata[CLR_OVF_BIT];
  assign ctrlZeroWr = regWe && regAddr == ADDR_W'(OFS_CTRL) && regWdata == '0;

  // R3: a detected change always lands in the edge flag
  p_edge_sets_flag_r3: assert property (@(posedge clk) disable iff (!rstN)
    edgeNow |=> edgeFlag);

  // R4: with no detected change the edge flag cannot rise
  p_no_spurious_edge_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!edgeNow && !edgeFlag) |=> !edgeFlag);

  // R5: change on a set edge flag raises overflow
  p_ovf_on_second_r5: assert property (@(posedge clk) disable iff (!rstN)
    (edgeNow && edgeFlag) |=> ovfFlag);

  // R5: overflow is sticky until its clear bit is written
  p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !clrOvfWr) |=> ovfFlag);

  // R6: an uncontested clear empties the edge flag
  p_clear_edge_r6: assert property (@(posedge clk) disable iff (!rstN)
    (clrEdgeWr && !edgeNow) |=> !edgeFlag);

  // R7: new change wins against a same-cycle clear
  p_new_edge_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
    (clrEdgeWr && edgeNow) |=> edgeFlag);

  // R8: no interrupt without a flag behind it
  p_irq_needs_flag_r8: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (edgeFlag || ovfFlag));

  // R8: status pending bit mirrors the interrupt line
  p_status_mirror_r8: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'(OFS_STATUS)) |-> (regRdata[2] == irqOut));

  // R9: zero control silences the interrupt
  p_ctrl_off_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctrlZeroWr |=> !irqOut);

endmodule

bind edge_irq_ctrl edge_irq_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
  .regWdata(regWdata), .regRdata(regRdata), .irqOut(irqOut),
  .edgeFlag(edgeFlag), .ovfFlag(ovfFlag), .edgeNow(edgeNow)
);

// File: tb/edge_irq_ctrl_tb_top.sv
module edge_irq_ctrl_tb_top;

  localparam int NP = 4;
  localparam int DW = 8;
  localparam int AW = 8;
  localparam int PW = NP * DW;

  logic          clk;
  logic          rstN;
  logic [PW-1:0] pinsIn;
  logic          regWe;
  logic [AW-1:0] regAddr;
  logic [DW-1:0] regWdata;
  logic [DW-1:0] regRdata;
  logic          irqOut;

  edge_irq_ctrl #(.NUM_PORTS(NP), .DATA_W(DW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rstN(rstN), .pinsIn(pinsIn), .regWe(regWe),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata), .irqOut(irqOut)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Reference model state
  logic [PW-1:0] prevM;
  logic [DW-1:0] riseM [NP];
  logic [DW-1:0] fallM [NP];
  logic [4:0]    ctrlM;
  logic          edgeM, ovfM;
  int            nChecks = 0;
  int            nFails  = 0;
  bit            finished = 0;

  function automatic logic [7:0] riseAddr(input int p); return 8'(8'h42 + 16 * p); endfunction
  function automatic logic [7:0] fallAddr(input int p); return 8'(8'h43 + 16 * p); endfunction

  function automatic logic expIrq();
    return ctrlM[2] && ((edgeM && ctrlM[0]) || (ovfM && ctrlM[1]));
  endfunction

  function automatic logic [7:0] expRead(input logic [7:0] a);
    logic [7:0] v = 8'h00;
    if (a == 8'h02) v = {5'b0, expIrq(), ovfM, edgeM};
    if (a == 8'h03) v = {3'b0, ctrlM};
    for (int p = 0; p < NP; p++) begin
      if (a == riseAddr(p)) v = riseM[p];
      if (a == fallAddr(p)) v = fallM[p];
    end
    return v;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One clock with the given stimulus; model advanced from pre-edge state.
  task automatic step(input logic [PW-1:0] p, input bit we, input logic [7:0] a, input logic [7:0] d);
    logic hit;
    logic nEdge, nOvf;
    @(negedge clk);
    pinsIn = p; regWe = we; regAddr = a; regWdata = d;
    hit = 1'b0;
    for (int i = 0; i < PW; i++) begin
      if (p[i] && !prevM[i] && riseM[i / DW][i % DW] && ctrlM[3]) hit = 1'b1;
      if (!p[i] && prevM[i] && fallM[i / DW][i % DW] && ctrlM[4]) hit = 1'b1;
    end
    nEdge = hit ? 1'b1 : ((we && a == 8'h01 && d[3]) ? 1'b0 : edgeM);
    nOvf  = (hit && edgeM) ? 1'b1 : ((we && a == 8'h01 && d[2]) ? 1'b0 : ovfM);
    @(posedge clk);
    #1;
    regWe = 1'b0;
    edgeM = nEdge;
    ovfM  = nOvf;
    prevM = p;
    if (we) begin
      if (a == 8'h03) ctrlM = d[4:0];
      for (int q = 0; q < NP; q++) begin
        if (a == riseAddr(q)) riseM[q] = d;
        if (a == fallAddr(q)) fallM[q] = d;
      end
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    step(pinsIn, 1'b1, a, d);
  endtask

  task automatic checkReg(input string tag, input logic [7:0] a);
    regAddr = a;
    #1;
    check(tag, regRdata, expRead(a));
  endtask

  task automatic checkAll(input string tag);
    check(tag, irqOut, expIrq());
    checkReg(tag, 8'h02);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [PW-1:0] pv;
    void'($urandom(32'd4711));
    rstN = 1'b0; pinsIn = '0; regWe = 1'b0; regAddr = '0; regWdata = '0;
    prevM = '0; ctrlM = '0; edgeM = 1'b0; ovfM = 1'b0;
    for (int p = 0; p < NP; p++) begin riseM[p] = '0; fallM[p] = '0; end
    repeat (4) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #1;

    // R1: reset state
    check("R1 irq", irqOut, 1'b0);
    checkReg("R1 status", 8'h02);
    checkReg("R1 ctrl", 8'h03);
    for (int p = 0; p < NP; p++) begin
      checkReg("R1 rise mask", riseAddr(p));
      checkReg("R1 fall mask", fallAddr(p));
    end

    // R2: register readback
    for (int p = 0; p < NP; p++) begin
      wr(riseAddr(p), 8'(8'h11 * (p + 1)));
      wr(fallAddr(p), 8'(8'hA0 + p));
    end
    wr(8'h03, 8'hFF);
    checkReg("R2 ctrl upper bits zero", 8'h03);
    check("R2 ctrl value", regRdata, 8'h1F);
    for (int p = 0; p < NP; p++) begin
      checkReg("R2 rise mask", riseAddr(p));
      checkReg("R2 fall mask", fallAddr(p));
    end

    // Setup: only port0 bit0 rising, port1 bit7 falling
    for (int p = 0; p < NP; p++) begin wr(riseAddr(p), 8'h00); wr(fallAddr(p), 8'h00); end
    wr(riseAddr(0), 8'h01);
    wr(fallAddr(1), 8'h80);
    wr(8'h03, 8'h1D);
    checkAll("R1 idle after setup");

    // R4: unmasked bit changes do nothing
    step(32'h0000_0002, 1'b0, 8'h02, 8'h00);
    checkAll("R4 masked bit");
    check("R4 edge flag stays clear", regRdata[0], 1'b0);

    // R3: rising detection, R8 interrupt
    step(32'h0000_0003, 1'b0, 8'h02, 8'h00);
    checkAll("R3 rising sets flag");
    check("R3 edge bit", regRdata[0], 1'b1);
    check("R8 irq on edge", irqOut, 1'b1);

    // R6: clear edge
    wr(8'h01, 8'h08);
    checkAll("R6 clear edge");
    check("R6 edge bit cleared", regRdata[0], 1'b0);

    // R4: global rising off blocks a masked-in rise
    wr(8'h03, 8'h15);
    step(32'h0000_0002, 1'b0, 8'h02, 8'h00);
    step(32'h0000_0003, 1'b0, 8'h02, 8'h00);
    checkAll("R4 rising disabled globally");
    check("R4 no flag", regRdata[0], 1'b0);

    // R3: falling detection on port1 bit7
    wr(8'h03, 8'h1D);
    step(32'h0000_8003, 1'b0, 8'h02, 8'h00);
    checkAll("R4 rising on port1 ignored");
    step(32'h0000_0003, 1'b0, 8'h02, 8'h00);
    checkAll("R3 falling sets flag");
    check("R3 falling edge bit", regRdata[0], 1'b1);

    // R5: second edge sets overflow, sticky
    step(32'h0000_0002, 1'b0, 8'h02, 8'h00);
    step(32'h0000_0003, 1'b0, 8'h02, 8'h00);
    checkAll("R5 overflow");
    check("R5 overflow bit", regRdata[1], 1'b1);
    step(32'h0000_0003, 1'b0, 8'h02, 8'h00);
    check("R5 overflow sticky", regRdata[1], 1'b1);

    // R8 + R6: overflow-only interrupt after clearing edge alone
    wr(8'h03, 8'h1E);
    wr(8'h01, 8'h08);
    checkAll("R6 edge cleared ovf kept");
    check("R6 ovf kept", regRdata[1:0], 2'b10);
    check("R8 irq from overflow", irqOut, 1'b1);

    // R9: control zero silences irq, flags kept
    wr(8'h03, 8'h00);
    checkAll("R9 ctrl off");
    check("R9 irq low", irqOut, 1'b0);
    check("R9 ovf kept", regRdata[1], 1'b1);
    wr(8'h01, 8'h04);
    checkAll("R6 clear ovf");

    // R7: clear and new edge same cycle
    wr(8'h03, 8'h1D);
    step(32'h0000_0002, 1'b0, 8'h02, 8'h00);
    step(32'h0000_0003, 1'b0, 8'h02, 8'h00);
    step(32'h0000_0002, 1'b0, 8'h02, 8'h00);
    step(32'h0000_0003, 1'b1, 8'h01, 8'h0C);
    checkAll("R7 edge wins");
    check("R7 edge bit kept", regRdata[0], 1'b1);

    // Random mix
    for (int n = 0; n < 600; n++) begin
      int sel;
      int prt;
      sel = int'($urandom_range(0, 7));
      prt = int'($urandom_range(0, NP - 1));
      pv = pinsIn ^ ($urandom & $urandom & $urandom);
      case (sel)
        0: step(pv, 1'b1, 8'h01, 8'($urandom) & 8'h0C);
        1: step(pv, 1'b1, 8'h03, 8'($urandom));
        2: step(pv, 1'b1, riseAddr(prt), 8'($urandom));
        3: step(pv, 1'b1, fallAddr(prt), 8'($urandom));
        default: step(pv, 1'b0, 8'h02, 8'h00);
      endcase
      checkAll("R8 random");
      if (n % 50 == 0) checkReg("R2 random readback", riseAddr(prt));
    end

    summary();
  end

endmodule